// File: doc/BRIEF.md
# Extension Identifier to Logical Unit Translator

This block carries out the translation step of a pluggable-extension scheme. The source operand names an extension interface by a wide identifier in its upper bits and picks one implementing device by a sequence number in its low 12 bits. The block searches a small associative table of (identifier, device) keys. Each entry maps a key to a 12-bit logical unit number. The result word packs that unit number into its low 12 bits. The bits above it hold caller data taken from the low end of the second operand.

The table is loaded at configuration time through a write port that writes one entry per cycle. A lookup only reads the table, so the translation leaves no state behind. A key that is not found returns unit zero; the block raises no fault. The lookup itself is combinational. Its result is captured in a single output register, which is guarded by a valid/ready handshake.

Top module: `xl_translator`

## Requirements
- R1: After reset, rsp_valid is 0 and every table entry is invalid, so any lookup returns unit 0 in result bits [11:0].
- R2: The key is the whole source operand: bits [11:0] are the device number and bits [XLEN-1:12] are the interface identifier. On a match, result bits [11:0] carry the stored unit of the matching valid entry.
- R3: When no valid entry matches, result bits [11:0] are 0.
- R4: Result bits [XLEN-1:12] equal bits [XLEN-13:0] of the data operand, and the data operand's upper 12 bits are dropped.
- R5: One identifier with different device numbers can map to different units, for example device 0 to unit 32 and device 1 to unit 34.
- R6: When several valid entries hold the same key, the entry with the lowest index supplies the unit.
- R7: An entry written with its valid flag at 0 never matches.
- R8: A configuration write at one clock edge is seen by a lookup that is accepted at the next edge.
- R9: A lookup leaves the table unchanged, so repeating a lookup with no writes in between gives the same result.
- R10: A request accepted at an edge sets rsp_valid after that edge. While rsp_valid is 1 and rsp_ready is 0, rsp_word stays stable and req_ready is 0. req_ready equals (not rsp_valid) or rsp_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_key | input | XLEN | Key: identifier above, device number in the low 12 bits |
| cfg_unit | input | 12 | Logical unit stored in the entry |
| cfg_vld | input | 1 | Valid flag stored in the entry |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_src | input | XLEN | Source operand (lookup key) |
| req_data | input | XLEN | Second operand (caller data) |
| rsp_valid | output | 1 | Result held in the output register |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_word | output | XLEN | Packed result {data, unit} |

## Verification
Lookups are tried with several patterns. A known key separates a hit from a miss. The same identifier with two device numbers shows that the device field takes part in the key. A key held by two entries exposes the priority order, and an entry written as invalid must be skipped. A data operand with all upper bits set shows whether truncation happens in the right place. A write followed by a lookup in the very next cycle tests whether the table is visible one cycle after a write. A stall on rsp_ready shows whether the result holds still and whether backpressure reaches the request side.

// File: rtl/xl_pkg.sv
package xl_pkg;
  // Width of the logical unit field, fixed by the translation scheme.
  localparam int unsigned UNIT_W = 12;
  // Default machine word width.
  localparam int unsigned DEF_XLEN = 32;
  // Default number of table entries.
  localparam int unsigned DEF_ENTRIES = 8;
endpackage

// File: rtl/xl_table.sv
module xl_table #(
  parameter int unsigned XLEN    = xl_pkg::DEF_XLEN,
  parameter int unsigned ENTRIES = xl_pkg::DEF_ENTRIES,
  parameter int unsigned UNIT_W  = xl_pkg::UNIT_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [XLEN-1:0]                  wr_key,
  input  logic [UNIT_W-1:0]                wr_unit,
  input  logic                             wr_vld,
  output logic [ENTRIES-1:0][XLEN-1:0]     key_q,
  output logic [ENTRIES-1:0][UNIT_W-1:0]   unit_q,
  output logic [ENTRIES-1:0]               vld_q
);
  logic [ENTRIES-1:0] vld_d;
  logic [ENTRIES-1:0] sel;

  // Decode of the write index into per-entry enables.
  always_comb begin
    sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      sel[i] = wr_en && (wr_idx == IDX_W'(i));
    end
  end

  always_comb begin
    vld_d = vld_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (sel[i]) vld_d[i] = wr_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q <= vld_d;
  end

  // Payload storage carries no reset; valid bits gate its use.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (sel[g]) begin
        key_q[g]  <= wr_key;
        unit_q[g] <= wr_unit;
      end
    end
  end

  // R9
  tbl_stateless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vld_q) && $stable(key_q) && $stable(unit_q));

  // R7
  tbl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)] == $past(wr_vld));
endmodule

// File: rtl/xl_match.sv
module xl_match #(
  parameter int unsigned XLEN    = xl_pkg::DEF_XLEN,
  parameter int unsigned ENTRIES = xl_pkg::DEF_ENTRIES,
  parameter int unsigned UNIT_W  = xl_pkg::UNIT_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ENTRIES-1:0][XLEN-1:0]     key_q,
  input  logic [ENTRIES-1:0][UNIT_W-1:0]   unit_q,
  input  logic [ENTRIES-1:0]               vld_q,
  input  logic [XLEN-1:0]                  probe,
  output logic [UNIT_W-1:0]                unit_out,
  output logic                             hit
);
  logic [ENTRIES-1:0] eq;
  logic [ENTRIES-1:0] grant;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = vld_q[g] && (key_q[g] == probe);
  end

  // Lowest index wins: scan from the top so lower entries overwrite.
  always_comb begin
    grant = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  always_comb begin
    unit_out = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      unit_out = unit_out | (grant[i] ? unit_q[i] : '0);
    end
  end

  assign hit = |grant;

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|eq) |-> unit_out == '0);
endmodule

// File: rtl/xl_pack.sv
module xl_pack #(
  parameter int unsigned XLEN   = xl_pkg::DEF_XLEN,
  parameter int unsigned UNIT_W = xl_pkg::UNIT_W,
  localparam int unsigned DATA_W = XLEN - UNIT_W
) (
  input  logic [UNIT_W-1:0] unit_in,
  input  logic [XLEN-1:0]   data_in,
  output logic [XLEN-1:0]   word_out
);
  assign word_out = {data_in[DATA_W-1:0], unit_in};
endmodule

// File: rtl/xl_translator.sv
module xl_translator #(
  parameter int unsigned XLEN    = xl_pkg::DEF_XLEN,
  parameter int unsigned ENTRIES = xl_pkg::DEF_ENTRIES,
  localparam int unsigned UNIT_W = xl_pkg::UNIT_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [XLEN-1:0]   cfg_key,
  input  logic [UNIT_W-1:0] cfg_unit,
  input  logic              cfg_vld,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [XLEN-1:0]   req_src,
  input  logic [XLEN-1:0]   req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [XLEN-1:0]   rsp_word
);
  logic [ENTRIES-1:0][XLEN-1:0]   tbl_key;
  logic [ENTRIES-1:0][UNIT_W-1:0] tbl_unit;
  logic [ENTRIES-1:0]             tbl_vld;
  logic [UNIT_W-1:0]              found_unit;
  logic                           found_hit;
  logic [XLEN-1:0]                packed_word;
  logic                           take;
  logic                           vld_d;
  logic                           vld_q;
  logic [XLEN-1:0]                word_q;

  xl_table #(.XLEN(XLEN), .ENTRIES(ENTRIES), .UNIT_W(UNIT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_key(cfg_key),
    .wr_unit(cfg_unit), .wr_vld(cfg_vld),
    .key_q(tbl_key), .unit_q(tbl_unit), .vld_q(tbl_vld)
  );

  xl_match #(.XLEN(XLEN), .ENTRIES(ENTRIES), .UNIT_W(UNIT_W)) u_match (
    .clk(clk), .rst_n(rst_n),
    .key_q(tbl_key), .unit_q(tbl_unit), .vld_q(tbl_vld),
    .probe(req_src), .unit_out(found_unit), .hit(found_hit)
  );

  xl_pack #(.XLEN(XLEN), .UNIT_W(UNIT_W)) u_pack (
    .unit_in(found_unit), .data_in(req_data), .word_out(packed_word)
  );

  assign req_ready = !vld_q || rsp_ready;
  assign take      = req_valid && req_ready;

  always_comb begin
    vld_d = vld_q;
    if (take)           vld_d = 1'b1;
    else if (rsp_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (take) word_q <= packed_word;
  end

  assign rsp_valid = vld_q;
  assign rsp_word  = word_q;

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_word));

  // R10
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R3
  miss_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !found_hit |=> rsp_word[UNIT_W-1:0] == '0);
endmodule

// File: tb/tb_xl_translator.sv
module tb_xl_translator;
  localparam int XLEN = 32;
  localparam int ENT  = 8;
  localparam int IW   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [XLEN-1:0] cfg_key = '0;
  logic [11:0] cfg_unit = '0;
  logic cfg_vld = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [XLEN-1:0] req_src = '0;
  logic [XLEN-1:0] req_data = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [XLEN-1:0] rsp_word;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R1";

  // Behavioural reference state
  logic [XLEN-1:0] m_key [ENT];
  logic [11:0]     m_unit[ENT];
  bit              m_vld [ENT];
  bit              e_valid = 0;
  logic [XLEN-1:0] e_word = '0;
  bit              model_on = 0;

  always #4 clk = ~clk;

  xl_translator #(.XLEN(XLEN), .ENTRIES(ENT)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_key(cfg_key), .cfg_unit(cfg_unit), .cfg_vld(cfg_vld),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_word(rsp_word)
  );

  function automatic logic [11:0] ref_find(logic [XLEN-1:0] k);
    for (int i = 0; i < ENT; i++)
      if (m_vld[i] && m_key[i] == k) return m_unit[i];
    return 12'd0;
  endfunction

  task automatic chk(string t, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // Reference update at each edge, then comparison 2 ns later.
  always @(posedge clk) begin
    if (model_on) begin
      bit acc;
      acc = req_valid && (!e_valid || rsp_ready);
      if (acc) begin
        e_valid = 1;
        e_word  = {req_data[XLEN-13:0], ref_find(req_src)};
      end else if (rsp_ready) begin
        e_valid = 0;
      end
      if (cfg_we) begin
        m_key[cfg_idx]  = cfg_key;
        m_unit[cfg_idx] = cfg_unit;
        m_vld[cfg_idx]  = cfg_vld;
      end
      #2;
      chk({tag, " rsp_valid"}, XLEN'(rsp_valid), XLEN'(e_valid));
      chk("R10 req_ready", XLEN'(req_ready), XLEN'(!e_valid || rsp_ready));
      if (e_valid) chk({tag, " rsp_word"}, rsp_word, e_word);
    end
  end

  task automatic wr(int idx, logic [XLEN-1:0] k, int u, bit v);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_key = k; cfg_unit = 12'(u); cfg_vld = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic look(logic [XLEN-1:0] s, logic [XLEN-1:0] d);
    req_valid = 1; req_src = s; req_data = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < ENT; i++) begin m_vld[i] = 0; m_key[i] = '0; m_unit[i] = '0; end
    #20 rst_n = 1;
    @(negedge clk);
    // R1: reset state and empty-table lookup
    chk("R1 rsp_valid after reset", XLEN'(rsp_valid), '0);
    model_on = 1;
    tag = "R1"; look({20'hABCDE, 12'd0}, 32'h0);
    @(negedge clk);
    // R2/R5: same identifier, two device numbers
    wr(0, {20'hABCDE, 12'd0}, 32, 1);
    wr(1, {20'hABCDE, 12'd1}, 34, 1);
    tag = "R2"; look({20'hABCDE, 12'd0}, 32'h0000_1111);
    tag = "R5"; look({20'hABCDE, 12'd1}, 32'h0000_2222);
    // R3: miss
    tag = "R3"; look({20'hABCDE, 12'd2}, 32'h0);
    tag = "R3"; look({20'hABCDF, 12'd0}, 32'h5);
    // R4: upper data bits dropped
    tag = "R4"; look({20'hABCDE, 12'd0}, 32'hFFFF_FFFF);
    tag = "R4"; look({20'hABCDE, 12'd1}, 32'hA5A5_A5A5);
    // R6: duplicate key, lowest index wins
    wr(3, {20'h12345, 12'd0}, 99, 1);
    wr(2, {20'h12345, 12'd0}, 33, 1);
    tag = "R6"; look({20'h12345, 12'd0}, 32'h0);
    // R7: entry written invalid
    wr(4, {20'hD0B0D, 12'd0}, 35, 0);
    tag = "R7"; look({20'hD0B0D, 12'd0}, 32'h0);
    // R8: write then lookup in the next cycle
    wr(5, {20'hD0B0D, 12'd7}, 35, 1);
    tag = "R8"; look({20'hD0B0D, 12'd7}, 32'h0000_0ABC);
    // R9: repeated lookups give the same result
    tag = "R9"; look({20'h12345, 12'd0}, 32'h1);
    tag = "R9"; look({20'h12345, 12'd0}, 32'h1);
    // R10: stall with backpressure
    tag = "R10";
    rsp_ready = 0;
    req_valid = 1; req_src = {20'hABCDE, 12'd1}; req_data = 32'h3;
    @(negedge clk);
    req_src = {20'hABCDE, 12'd0}; req_data = 32'h4;
    repeat (3) @(negedge clk);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule